// File: doc/BRIEF.md
# Dual-Rail Enable Sequencing Controller

This block is the digital sequencer for a pair of regulator channels. Two enable requests, an input-supply-good level from an undervoltage comparator with hysteresis, and a "channel 1 output at target" flag come in from the analog side. The controller brings up the shared support circuitry in a fixed order, then grants a ramp enable to each channel. Channel 2's grant depends on how the two requests arrived relative to each other and to channel 1's progress.

All four inputs pass through two-flop synchronizers. The state machine has these states: SQ_OFF (shutdown), SQ_UVWAIT (waiting for the supply-good level), SQ_TRIM (one-cycle trim-latch strobe), SQ_BG (bandgap on), SQ_REF (reference on), SQ_BIAS (bias currents on), SQ_CHG (bypass fast charge) and SQ_RUN (channels may ramp). The transitions are:

- SQ_OFF to SQ_UVWAIT on any enable.
- SQ_UVWAIT to SQ_TRIM when supply-good is seen.
- SQ_TRIM to SQ_BG after one cycle.
- SQ_BG, SQ_REF, SQ_BIAS and SQ_CHG each advance to the next state after their programmed cycle count; SQ_CHG leads to SQ_RUN.
- Any state to SQ_OFF when both enables are low.
- Any state from SQ_TRIM onward to SQ_UVWAIT when supply-good drops.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While both synchronized enables are low, the next state is SQ_OFF. From the following cycle, every stage output and both ramp enables are 0. Any later enable restarts the full sequence from SQ_UVWAIT.
- R2: After an enable, no stage output rises until the synchronized supply-good input is 1. The trim strobe goes high on the third rising edge after supply-good rises, provided the controller is already waiting.
- R3: The bring-up order is trim strobe (exactly one cycle), then bandgap, then reference, then bias, then bypass charge. These last BG_CYC, REF_CYC, BIAS_CYC and CHG_CYC cycles respectively. Bandgap, reference and bias stay on through SQ_RUN. Bypass charge is high only in SQ_CHG.
- R4: When both enables rise in the same cycle, channel 1 ramps first. Channel 2 waits until channel 1 is ramping and its output flag reports target.
- R5: With channel 1 requested, channel 2 requested later does not ramp until channel 1's output flag reports target.
- R6: If enable 2 rose first but enable 1 rises before channel 2 has begun ramping, channel 1 ramps first and channel 2 waits for channel 1's target flag.
- R7: If enable 1 rises while channel 2 is already ramping, channel 1 ramps without waiting, and channel 2 keeps ramping.
- R8: When supply-good falls, both ramp enables and all stage outputs are 0 from the edge after it is synchronized. On recovery, the whole bring-up repeats.
- R9: Lowering one enable turns off only that channel's ramp enable.
- R10: In SQ_RUN, a rising enable 1 with no other blocker sets ramp enable 1 on the third rising edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en1_i | input | 1 | Channel 1 enable request (asynchronous) |
| en2_i | input | 1 | Channel 2 enable request (asynchronous) |
| supply_ok_i | input | 1 | 1 when input supply is above the rising threshold, 0 after it falls below the falling threshold |
| ch1_at_tgt_i | input | 1 | Channel 1 output has reached its target |
| trim_latch_o | output | 1 | One-cycle trim capture strobe |
| bg_en_o | output | 1 | Bandgap enable |
| ref_en_o | output | 1 | Reference enable |
| bias_en_o | output | 1 | Bias current generator enable |
| byp_chg_o | output | 1 | Bypass capacitor fast-charge enable |
| ramp1_en_o | output | 1 | Channel 1 ramp enable |
| ramp2_en_o | output | 1 | Channel 2 ramp enable |

## Verification
The assertions assume that supply-good and the channel 1 target flag are clean levels. They also assume the target flag only reports target after channel 1 has been ramping for a while, as a real output would. The stimulus keeps to this: a small plant model in the bench drives the target flag from the observed ramp enable 1 after a fixed delay. Random enable and supply-good changes are held for many cycles, so synchronized levels settle between changes.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [2:0] {
        SQ_OFF, SQ_UVWAIT, SQ_TRIM, SQ_BG, SQ_REF, SQ_BIAS, SQ_CHG, SQ_RUN
    } seq_state_e;

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        m = (m > d) ? m : d;
        return m;
    endfunction
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q, stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= d_i[b];
                stable_q <= meta_q;
            end
        end
        assign q_o[b] = stable_q;
    end
endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import rs_pkg::*;
#(
    parameter int BG_CYC   = 16,
    parameter int REF_CYC  = 16,
    parameter int BIAS_CYC = 16,
    parameter int CHG_CYC  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_en,
    input  logic       supply_ok,
    output seq_state_e state_o,
    output logic       trim_latch_o,
    output logic       bg_en_o,
    output logic       ref_en_o,
    output logic       bias_en_o,
    output logic       byp_chg_o
);
    localparam int MAXC  = max4(BG_CYC, REF_CYC, BIAS_CYC, CHG_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, lim;
    logic             timed;

    always_comb begin
        timed = 1'b1;
        lim   = '0;
        unique case (state)
            SQ_BG:   lim = CNT_W'(BG_CYC - 1);
            SQ_REF:  lim = CNT_W'(REF_CYC - 1);
            SQ_BIAS: lim = CNT_W'(BIAS_CYC - 1);
            SQ_CHG:  lim = CNT_W'(CHG_CYC - 1);
            default: timed = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        if (!any_en) begin
            nxt = SQ_OFF;
        end else if (!supply_ok && (state != SQ_OFF) && (state != SQ_UVWAIT)) begin
            nxt = SQ_UVWAIT;
        end else begin
            unique case (state)
                SQ_OFF:    nxt = SQ_UVWAIT;
                SQ_UVWAIT: nxt = supply_ok ? SQ_TRIM : SQ_UVWAIT;
                SQ_TRIM:   nxt = SQ_BG;
                SQ_BG:     nxt = (cnt == lim) ? SQ_REF  : SQ_BG;
                SQ_REF:    nxt = (cnt == lim) ? SQ_BIAS : SQ_REF;
                SQ_BIAS:   nxt = (cnt == lim) ? SQ_CHG  : SQ_BIAS;
                SQ_CHG:    nxt = (cnt == lim) ? SQ_RUN  : SQ_CHG;
                SQ_RUN:    nxt = SQ_RUN;
                default:   nxt = SQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state || !timed) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        trim_latch_o = 1'b0;
        bg_en_o      = 1'b0;
        ref_en_o     = 1'b0;
        bias_en_o    = 1'b0;
        byp_chg_o    = 1'b0;
        unique case (state)
            SQ_TRIM: trim_latch_o = 1'b1;
            SQ_BG:   bg_en_o = 1'b1;
            SQ_REF:  begin bg_en_o = 1'b1; ref_en_o = 1'b1; end
            SQ_BIAS: begin bg_en_o = 1'b1; ref_en_o = 1'b1; bias_en_o = 1'b1; end
            SQ_CHG:  begin bg_en_o = 1'b1; ref_en_o = 1'b1; bias_en_o = 1'b1; byp_chg_o = 1'b1; end
            SQ_RUN:  begin bg_en_o = 1'b1; ref_en_o = 1'b1; bias_en_o = 1'b1; end
            default: ;
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/rs_grant.sv
module rs_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic en1,
    input  logic en2,
    input  logic ch1_at_tgt,
    output logic ramp1_o,
    output logic ramp2_o
);
    logic ch2_clear;

    // Channel 2 may start when channel 1 is not requested, or channel 1 is up.
    assign ch2_clear = !en1 || (ramp1_o && ch1_at_tgt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp1_o <= 1'b0;
            ramp2_o <= 1'b0;
        end else begin
            ramp1_o <= run && en1;
            ramp2_o <= run && en2 && (ramp2_o || ch2_clear);
        end
    end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rs_pkg::*;
#(
    parameter int BG_CYC   = 16,
    parameter int REF_CYC  = 16,
    parameter int BIAS_CYC = 16,
    parameter int CHG_CYC  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en1_i,
    input  logic en2_i,
    input  logic supply_ok_i,
    input  logic ch1_at_tgt_i,
    output logic trim_latch_o,
    output logic bg_en_o,
    output logic ref_en_o,
    output logic bias_en_o,
    output logic byp_chg_o,
    output logic ramp1_en_o,
    output logic ramp2_en_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] sync_q;
    logic             en1_q, en2_q, uvok_q, vo1_q;
    seq_state_e       state;
    logic             run;

    rs_sync #(.W(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({en1_i, en2_i, supply_ok_i, ch1_at_tgt_i}),
        .q_o   (sync_q)
    );

    assign {en1_q, en2_q, uvok_q, vo1_q} = sync_q;

    rs_seq #(
        .BG_CYC   (BG_CYC),
        .REF_CYC  (REF_CYC),
        .BIAS_CYC (BIAS_CYC),
        .CHG_CYC  (CHG_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_en       (en1_q | en2_q),
        .supply_ok    (uvok_q),
        .state_o      (state),
        .trim_latch_o (trim_latch_o),
        .bg_en_o      (bg_en_o),
        .ref_en_o     (ref_en_o),
        .bias_en_o    (bias_en_o),
        .byp_chg_o    (byp_chg_o)
    );

    assign run = (state == SQ_RUN) && uvok_q;

    rs_grant u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .en1        (en1_q),
        .en2        (en2_q),
        .ch1_at_tgt (vo1_q),
        .ramp1_o    (ramp1_en_o),
        .ramp2_o    (ramp2_en_o)
    );
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en1_q,
    input logic en2_q,
    input logic uvok_q,
    input logic vo1_q,
    input logic trim_latch_o,
    input logic bg_en_o,
    input logic ref_en_o,
    input logic bias_en_o,
    input logic byp_chg_o,
    input logic ramp1_en_o,
    input logic ramp2_en_o
);
    AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en1_q && !en2_q) |=> !(trim_latch_o | bg_en_o | ref_en_o | bias_en_o | byp_chg_o | ramp1_en_o | ramp2_en_o)); // R1
    AST_TRIM_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trim_latch_o) |-> $past(uvok_q)); // R2
    AST_TRIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trim_latch_o |=> !trim_latch_o); // R3
    AST_BG_AFTER_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bg_en_o) |-> $past(trim_latch_o)); // R3
    AST_REF_AFTER_BG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en_o) |-> $past(bg_en_o)); // R3
    AST_BIAS_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bias_en_o) |-> $past(ref_en_o)); // R3
    AST_CHG_AFTER_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byp_chg_o) |-> $past(bias_en_o)); // R3
    AST_RAMP_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp1_en_o || ramp2_en_o) |-> (bias_en_o && !byp_chg_o)); // R3
    AST_CH2_WAITS_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp2_en_o) |-> (!$past(en1_q) || ($past(ramp1_en_o) && $past(vo1_q)))); // R4
    AST_CH2_KEEPS_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp2_en_o && en2_q && uvok_q) |=> ramp2_en_o); // R7
    AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !uvok_q |=> !(ramp1_en_o | ramp2_en_o | bg_en_o | byp_chg_o)); // R8
    AST_CH1_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !en1_q |=> !ramp1_en_o); // R9
    AST_CH2_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !en2_q |=> !ramp2_en_o); // R9
endmodule

bind rail_seq_ctrl rail_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en1_q        (en1_q),
    .en2_q        (en2_q),
    .uvok_q       (uvok_q),
    .vo1_q        (vo1_q),
    .trim_latch_o (trim_latch_o),
    .bg_en_o      (bg_en_o),
    .ref_en_o     (ref_en_o),
    .bias_en_o    (bias_en_o),
    .byp_chg_o    (byp_chg_o),
    .ramp1_en_o   (ramp1_en_o),
    .ramp2_en_o   (ramp2_en_o)
);

// File: tb/tb_rail_seq_ctrl.sv
`timescale 1ns/1ps
module tb_rail_seq_ctrl;
    localparam int BGC = 4, RFC = 3, BSC = 5, CGC = 6, RAMP_T = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en1 = 1'b0, en2 = 1'b0, uv = 1'b0, vo1 = 1'b0;
    logic trim, bg, rf, bs, chg, r1, r2;

    always #2.5 clk = ~clk;

    rail_seq_ctrl #(.BG_CYC(BGC), .REF_CYC(RFC), .BIAS_CYC(BSC), .CHG_CYC(CGC)) dut (
        .clk(clk), .rst_n(rst_n), .en1_i(en1), .en2_i(en2), .supply_ok_i(uv),
        .ch1_at_tgt_i(vo1), .trim_latch_o(trim), .bg_en_o(bg), .ref_en_o(rf),
        .bias_en_o(bs), .byp_chg_o(chg), .ramp1_en_o(r1), .ramp2_en_o(r2)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Plant: output 1 reaches target RAMP_T cycles after its ramp enable is seen high.
    int pc = 0;
    always @(negedge clk) begin
        if (!rst_n) begin pc = 0; vo1 = 1'b0; end
        else begin
            pc  = r1 ? pc + 1 : 0;
            vo1 = (pc >= RAMP_T);
        end
    end

    // Reference model built from the requirements.
    logic [3:0] q1 = '0, q2 = '0;
    int  mst = 0, rem = 0;
    bit  mr1 = 0, mr2 = 0;

    function automatic int stage_len(int s);
        case (s)
            3: return BGC;
            4: return RFC;
            5: return BSC;
            6: return CGC;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q1 = '0; q2 = '0; mst = 0; rem = 0; mr1 = 0; mr2 = 0;
        end else begin
            bit e1, e2, u, v, run, n1, n2;
            int ns;
            {e1, e2, u, v} = q2;
            run = (mst == 7) && u;
            n1  = run && e1;
            n2  = run && e2 && (mr2 || !e1 || (mr1 && v));
            if (!(e1 || e2))          ns = 0;
            else if (!u && mst >= 2)  ns = 1;
            else if (mst == 0)        ns = 1;
            else if (mst == 1)        ns = u ? 2 : 1;
            else if (mst == 2)        ns = 3;
            else if (mst == 7)        ns = 7;
            else                      ns = (rem == 1) ? mst + 1 : mst;
            if (ns != mst) rem = stage_len(ns);
            else if (mst >= 3 && mst <= 6) rem--;
            mst = ns; mr1 = n1; mr2 = n2;
            q2 = q1; q1 = {en1, en2, uv, vo1};
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R3", "trim",   trim, mst == 2);
            chk("R3", "bg",     bg,   mst >= 3);
            chk("R3", "ref",    rf,   mst >= 4);
            chk("R3", "bias",   bs,   mst >= 5);
            chk("R3", "bypchg", chg,  mst == 6);
            chk("R10", "ramp1", r1,   mr1);
            chk("R5", "ramp2",  r2,   mr2);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_r1;
        for (int k = 0; k < 100 && !r1; k++) @(negedge clk);
    endtask

    task automatic wait_r2;
        for (int k = 0; k < 100 && !r2; k++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        cyc(4);
        chk("R1", "reset bg", bg, 1'b0);
        chk("R1", "reset ramp1", r1, 1'b0);
        rst_n = 1'b1;

        // R2: waits for supply-good
        en1 = 1'b1; cyc(20);
        chk("R2", "bg held off", bg, 1'b0);
        chk("R2", "trim held off", trim, 1'b0);
        uv = 1'b1; cyc(2);
        chk("R2", "trim before 3rd edge", trim, 1'b0);
        cyc(1);
        chk("R2", "trim on 3rd edge", trim, 1'b1);
        cyc(1);
        chk("R3", "trim single", trim, 1'b0);
        chk("R3", "bg after trim", bg, 1'b1);
        cyc(BGC - 1);
        chk("R3", "ref not yet", rf, 1'b0);
        cyc(1);
        chk("R3", "ref after bg", rf, 1'b1);

        // R5: channel 2 requested while channel 1 still ramping
        wait_r1();
        chk("R5", "ramp1 up", r1, 1'b1);
        en2 = 1'b1; cyc(4);
        chk("R5", "ramp2 waits", r2, 1'b0);
        cyc(20);
        chk("R5", "ramp2 after target", r2, 1'b1);

        // R9: single-channel drop
        en2 = 1'b0; cyc(3);
        chk("R9", "ramp2 off", r2, 1'b0);
        chk("R9", "ramp1 stays", r1, 1'b1);
        en2 = 1'b1; cyc(20);
        en1 = 1'b0; cyc(3);
        chk("R9", "ramp1 off", r1, 1'b0);
        chk("R9", "ramp2 stays", r2, 1'b1);

        // R10: synchronizer + grant latency
        en1 = 1'b1; cyc(2);
        chk("R10", "ramp1 not before 3rd edge", r1, 1'b0);
        cyc(1);
        chk("R10", "ramp1 on 3rd edge", r1, 1'b1);
        chk("R7", "ramp2 kept", r2, 1'b1);
        cyc(20);

        // R8: supply loss and recovery
        uv = 1'b0; cyc(3);
        chk("R8", "ramp1 off", r1, 1'b0);
        chk("R8", "ramp2 off", r2, 1'b0);
        chk("R8", "bg off", bg, 1'b0);
        uv = 1'b1;
        wait_r1();
        chk("R8", "resequenced ramp1", r1, 1'b1);
        chk("R8", "ramp2 behind", r2, 1'b0);
        cyc(30);

        // R1: both enables low
        en1 = 1'b0; en2 = 1'b0; cyc(3);
        chk("R1", "bias off", bs, 1'b0);
        chk("R1", "ramp1 off", r1, 1'b0);
        chk("R1", "ramp2 off", r2, 1'b0);

        // R4: simultaneous request
        en1 = 1'b1; en2 = 1'b1;
        wait_r1();
        chk("R4", "ramp1 first", r1, 1'b1);
        chk("R4", "ramp2 not yet", r2, 1'b0);
        cyc(30);
        chk("R4", "ramp2 later", r2, 1'b1);

        // R6: enable 2 first, enable 1 before channel 2 ramps
        en1 = 1'b0; en2 = 1'b0; cyc(5);
        en2 = 1'b1; cyc(8);
        en1 = 1'b1;
        wait_r1();
        chk("R6", "ramp1 first", r1, 1'b1);
        chk("R6", "ramp2 waits", r2, 1'b0);
        cyc(30);
        chk("R6", "ramp2 later", r2, 1'b1);

        // R7: enable 1 after channel 2 ramping
        en1 = 1'b0; en2 = 1'b0; cyc(5);
        en2 = 1'b1;
        wait_r2();
        cyc(2);
        en1 = 1'b1; cyc(3);
        chk("R7", "ramp1 immediate", r1, 1'b1);
        chk("R7", "ramp2 continues", r2, 1'b1);

        // Random phase, checked against the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(39, 0) == 0) en1 = ~en1;
            if ($urandom_range(39, 0) == 0) en2 = ~en2;
            if (uv) begin
                if ($urandom_range(299, 0) == 0) uv = 1'b0;
            end else if ($urandom_range(9, 0) == 0) uv = 1'b1;
        end
        cyc(2);
        finish_run();
    end
endmodule